// File: doc/BRIEF.md
# Length-Changing Prefix Stall Detector

This block sits in front of an instruction decoder that runs with a 32-bit default operand size. Each cycle it can take a 16-byte window of fetched code, with byte 0 as the first byte of the instruction. It counts the prefix bytes at the start of the window. For a small set of opcodes it works out the total instruction length. It also raises a stall flag when an operand-size override would make the real decoder take its slow path.

Two opcodes are handled. The first is the accumulator XOR with an immediate (0x35). The second is the 0xF7 group, but only in register-direct form. Any other opcode, any memory form of 0xF7, and any instruction longer than 15 bytes is reported as bad.

A two-state controller reports the result. In `ST_IDLE` no result is shown. The transition `go_report` (strobe seen) moves to `ST_REPORT`, where the result captured on that edge is presented. While strobes keep arriving, the transition `stay_report` keeps the block in `ST_REPORT`, one result per cycle. The transition `drop_idle` (no strobe) returns to `ST_IDLE`.

Top module: `lcp_stall_detect`

## Requirements
- R1: A result appears on the outputs exactly one clock after a cycle with `in_valid` high. After a cycle with `in_valid` low, both `out_len_vld` and `out_bad` are low.
- R2: `out_pfx_cnt` gives the length of the leading run of prefix bytes, from 0 to 16, counting each repeat separately. It is reported for legal and bad results alike. The prefix bytes are 66, 67, F0, F2, F3, 2E, 36, 3E, 26, 64 and 65 (hex).
- R3: Opcode 0x35 has a length of prefixes + 5, or prefixes + 3 when a 0x66 byte is among the prefixes (for example, 66 35 FF FF is 4 bytes).
- R4: Opcode 0xF7 with ModRM bits [7:6] = 11 has a length of prefixes + 2 when the ModRM reg field (bits [5:3]) is 2 to 7, whatever the prefixes. When the reg field is 0 or 1, it has a length of prefixes + 6, or prefixes + 4 with a 0x66 byte present.
- R5: `out_lcp_stall` is high exactly when the result is legal and a 0x66 byte is among the prefixes. This holds for both opcodes, including the 0xF7 forms whose length does not change.
- R6: Each 0x67 byte and each other non-0x66 prefix byte adds one byte to the length and never sets `out_lcp_stall`.
- R7: An opcode other than 0x35 or 0xF7, or an 0xF7 whose ModRM bits [7:6] are not 11, gives `out_bad` high, `out_len` = 0 and `out_lcp_stall` low.
- R8: A total length above 15 gives `out_bad`. This includes a window made only of prefix bytes.
- R9: `out_len_vld` and `out_bad` are never high together. A legal result has `out_len` in the range 2 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Window strobe |
| in_win | input | 128 | Code window; byte i is bits [8i+7:8i] |
| out_len_vld | output | 1 | Legal result present |
| out_bad | output | 1 | Illegal or unsupported result present |
| out_len | output | 4 | Instruction length in bytes, 0 when bad |
| out_pfx_cnt | output | 5 | Number of leading prefix bytes |
| out_lcp_stall | output | 1 | Decode penalty from an operand-size prefix |

## Verification
Three judgements can land on the same instruction: the length is legal, the stall is raised, and the length limit is crossed. The bench provokes this with 0x66-bearing prefix runs that grow until the limit is passed. It then checks that the stall drops in exactly the cycle the result turns bad. A second collision is a 0x66 on an 0xF7 form with no immediate: the length must stay the same while the stall is still raised. Every ModRM value is swept under several prefix mixes, and the expected length is computed byte by byte in the bench.

// File: rtl/lcp_pkg.sv
package lcp_pkg;

    localparam int WIN_BYTES = 16;
    localparam int MAX_LEN   = 15;
    localparam int LEN_W     = $clog2(MAX_LEN + 1);
    localparam int CNT_W     = $clog2(WIN_BYTES + 1);

    localparam logic [7:0] OPC_XOR_ACC = 8'h35;
    localparam logic [7:0] OPC_GRP_F7  = 8'hF7;
    localparam logic [7:0] PFX_OPSIZE  = 8'h66;
    localparam logic [7:0] PFX_ADSIZE  = 8'h67;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } lcp_state_e;

    function automatic logic lcp_is_prefix(input logic [7:0] b);
        unique case (b)
            8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3,
            8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65: return 1'b1;
            default:                                   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lcp_prefix_scan.sv
module lcp_prefix_scan
    import lcp_pkg::*;
#(
    parameter int NB = WIN_BYTES,
    parameter int CW = CNT_W
) (
    input  logic [8*NB-1:0] win,
    output logic [CW-1:0]   pfx_cnt,
    output logic            opsz_seen
);

    logic [NB-1:0] is_pfx;
    logic [NB-1:0] in_run;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign is_pfx[g] = lcp_is_prefix(win[8*g +: 8]);
        if (g == 0) begin : g_first
            assign in_run[g] = is_pfx[g];
        end else begin : g_next
            assign in_run[g] = in_run[g-1] & is_pfx[g];
        end
    end

    always_comb begin
        pfx_cnt   = '0;
        opsz_seen = 1'b0;
        for (int i = 0; i < NB; i++) begin
            pfx_cnt   = pfx_cnt + {{(CW-1){1'b0}}, in_run[i]};
            opsz_seen = opsz_seen | (in_run[i] && (win[8*i +: 8] == PFX_OPSIZE));
        end
    end

endmodule

// File: rtl/lcp_len_calc.sv
module lcp_len_calc
    import lcp_pkg::*;
#(
    parameter int NB   = WIN_BYTES,
    parameter int CW   = CNT_W,
    parameter int LW   = LEN_W,
    parameter int LMAX = MAX_LEN
) (
    input  logic [8*NB-1:0] win,
    input  logic [CW-1:0]   pfx_cnt,
    input  logic            opsz_seen,
    output logic [LW-1:0]   len,
    output logic            stall,
    output logic            bad
);

    localparam int TW = CW + 2;

    logic [7:0]    opc;
    logic [7:0]    modrm;
    logic          have_opc;
    logic          have_modrm;
    logic          supported;
    logic [TW-1:0] imm_sz;
    logic [TW-1:0] base_len;
    logic [TW-1:0] total;
    logic [CW:0]   modrm_idx;

    always_comb begin
        opc       = 8'h00;
        modrm     = 8'h00;
        modrm_idx = {1'b0, pfx_cnt} + 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (pfx_cnt == CW'(i))        opc   = win[8*i +: 8];
            if (modrm_idx == (CW+1)'(i))  modrm = win[8*i +: 8];
        end
        have_opc   = ({1'b0, pfx_cnt} < (CW+1)'(NB));
        have_modrm = (modrm_idx < (CW+1)'(NB));
    end

    always_comb begin
        imm_sz    = opsz_seen ? TW'(2) : TW'(4);
        supported = 1'b0;
        base_len  = '0;
        if (have_opc && opc == OPC_XOR_ACC) begin
            supported = 1'b1;
            base_len  = TW'(1) + imm_sz;
        end else if (have_opc && have_modrm && opc == OPC_GRP_F7 && modrm[7:6] == 2'b11) begin
            supported = 1'b1;
            base_len  = (modrm[5:3] <= 3'd1) ? (TW'(2) + imm_sz) : TW'(2);
        end
        total = {2'b00, pfx_cnt} + base_len;
        bad   = !supported || (total > TW'(LMAX));
        len   = bad ? '0 : total[LW-1:0];
        stall = !bad && opsz_seen;
    end

endmodule

// File: rtl/lcp_stall_detect.sv
module lcp_stall_detect
    import lcp_pkg::*;
#(
    parameter int NB   = WIN_BYTES,
    parameter int LMAX = MAX_LEN,
    parameter int LW   = $clog2(LMAX + 1),
    parameter int CW   = $clog2(NB + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [8*NB-1:0] in_win,
    output logic            out_len_vld,
    output logic            out_bad,
    output logic [LW-1:0]   out_len,
    output logic [CW-1:0]   out_pfx_cnt,
    output logic            out_lcp_stall
);

    lcp_state_e state_q;
    lcp_state_e state_d;

    logic [CW-1:0] scan_cnt;
    logic          scan_opsz;
    logic [LW-1:0] calc_len;
    logic          calc_stall;
    logic          calc_bad;

    logic [LW-1:0] len_q;
    logic [CW-1:0] cnt_q;
    logic          stall_q;
    logic          bad_q;

    lcp_prefix_scan #(.NB(NB), .CW(CW)) u_scan (
        .win       (in_win),
        .pfx_cnt   (scan_cnt),
        .opsz_seen (scan_opsz)
    );

    lcp_len_calc #(.NB(NB), .CW(CW), .LW(LW), .LMAX(LMAX)) u_calc (
        .win       (in_win),
        .pfx_cnt   (scan_cnt),
        .opsz_seen (scan_opsz),
        .len       (calc_len),
        .stall     (calc_stall),
        .bad       (calc_bad)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid) state_d = ST_REPORT;   // go_report
            ST_REPORT: if (!in_valid) state_d = ST_IDLE;    // drop_idle, else stay_report
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            cnt_q   <= '0;
            stall_q <= 1'b0;
            bad_q   <= 1'b0;
        end else if (in_valid) begin
            len_q   <= calc_len;
            cnt_q   <= scan_cnt;
            stall_q <= calc_stall;
            bad_q   <= calc_bad;
        end else begin
            len_q   <= '0;
            cnt_q   <= '0;
            stall_q <= 1'b0;
            bad_q   <= 1'b0;
        end
    end

    assign out_len_vld   = (state_q == ST_REPORT) && !bad_q;
    assign out_bad       = (state_q == ST_REPORT) && bad_q;
    assign out_len       = len_q;
    assign out_pfx_cnt   = cnt_q;
    assign out_lcp_stall = (state_q == ST_REPORT) && stall_q;

endmodule

// File: rtl/lcp_stall_chk.sv
module lcp_stall_chk #(
    parameter int LW = 4,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_len_vld,
    input logic          out_bad,
    input logic [LW-1:0] out_len,
    input logic [CW-1:0] out_pfx_cnt,
    input logic          out_lcp_stall
);

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_len_vld ^ out_bad));

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(out_len_vld || out_bad));

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_len_vld && out_bad));

    p_len_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_len_vld |-> (out_len >= LW'(2)));

    p_bad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_bad |-> (out_len == '0 && !out_lcp_stall));

    p_stall_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_lcp_stall |-> out_len_vld);

    p_pfx_lt_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_len_vld |-> ({1'b0, out_pfx_cnt} < (CW+1)'(out_len)));

endmodule

bind lcp_stall_detect lcp_stall_chk #(.LW(LW), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .out_len_vld   (out_len_vld),
    .out_bad       (out_bad),
    .out_len       (out_len),
    .out_pfx_cnt   (out_pfx_cnt),
    .out_lcp_stall (out_lcp_stall)
);

// File: tb/lcp_stall_detect_bench.sv
module lcp_stall_detect_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_win = '0;
    logic         out_len_vld;
    logic         out_bad;
    logic [3:0]   out_len;
    logic [4:0]   out_pfx_cnt;
    logic         out_lcp_stall;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] wb [16];
    logic [7:0] plist [11] = '{8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3, 8'h2E,
                               8'h36, 8'h3E, 8'h26, 8'h64, 8'h65};

    always #5 clk = ~clk;

    lcp_stall_detect u_lcp_stall_detect (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_win        (in_win),
        .out_len_vld   (out_len_vld),
        .out_bad       (out_bad),
        .out_len       (out_len),
        .out_pfx_cnt   (out_pfx_cnt),
        .out_lcp_stall (out_lcp_stall)
    );

    function automatic bit is_pfx(input logic [7:0] b);
        for (int i = 0; i < 11; i++) if (plist[i] == b) return 1'b1;
        return 1'b0;
    endfunction

    task automatic report(input string tag, input bit ok,
                          input int av, ab, al, ap, as_, ev, eb, el, ep, es);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual vld=%0d bad=%0d len=%0d pfx=%0d stall=%0d expected vld=%0d bad=%0d len=%0d pfx=%0d stall=%0d",
                     tag, av, ab, al, ap, as_, ev, eb, el, ep, es);
        end
    endtask

    // Called at a falling edge; presents wb, checks one cycle later.
    task automatic run_win(input string tag);
        int n, len, imm;
        bit op66, sup, bad;
        for (int i = 0; i < 16; i++) in_win[8*i +: 8] = wb[i];
        in_valid = 1'b1;
        n = 0;
        op66 = 1'b0;
        while (n < 16 && is_pfx(wb[n])) begin
            if (wb[n] == 8'h66) op66 = 1'b1;
            n++;
        end
        imm = op66 ? 2 : 4;
        sup = 1'b0;
        len = 0;
        if (n < 16 && wb[n] == 8'h35) begin
            sup = 1'b1; len = n + 1 + imm;
        end else if (n < 15 && wb[n] == 8'hF7 && wb[n+1][7:6] == 2'b11) begin
            sup = 1'b1; len = n + 2 + ((wb[n+1][5:3] <= 1) ? imm : 0);
        end
        bad = !sup || len > 15;
        if (bad) len = 0;
        @(negedge clk);
        report(tag,
               out_len_vld == !bad && out_bad == bad && int'(out_len) == len &&
               int'(out_pfx_cnt) == n && out_lcp_stall == (!bad && op66),
               out_len_vld, out_bad, out_len, out_pfx_cnt, out_lcp_stall,
               !bad, bad, len, n, !bad && op66);
    endtask

    function automatic int put_pfx(input int pv);
        unique case (pv)
            0: return 0;
            1: begin wb[0] = 8'h66; return 1; end
            2: begin wb[0] = 8'h67; return 1; end
            3: begin wb[0] = 8'h66; wb[1] = 8'h67; return 2; end
            4: begin wb[0] = 8'hF3; return 1; end
            default: begin wb[0] = 8'h2E; wb[1] = 8'h66; wb[2] = 8'h66; return 3; end
        endcase
    endfunction

    function automatic void fill();
        for (int i = 0; i < 16; i++) wb[i] = 8'hA0 + 8'(i);
    endfunction

    initial begin
        int p;
        repeat (3) @(negedge clk);
        // Reset state: no result shown.
        report("R1 reset", !out_len_vld && !out_bad && out_len == 0 && out_pfx_cnt == 0 && !out_lcp_stall,
               out_len_vld, out_bad, out_len, out_pfx_cnt, out_lcp_stall, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R5 R6: accumulator XOR under each prefix mix.
        for (int pv = 0; pv < 6; pv++) begin
            fill();
            p = put_pfx(pv);
            wb[p] = 8'h35;
            wb[p+1] = 8'hFF; wb[p+2] = 8'hFF;
            run_win("R3 R5 R6 xor-acc");
        end

        // R4 R5 R7: every ModRM value of 0xF7 under each prefix mix.
        for (int m = 0; m < 256; m++) begin
            for (int pv = 0; pv < 6; pv++) begin
                fill();
                p = put_pfx(pv);
                wb[p] = 8'hF7;
                wb[p+1] = 8'(m);
                run_win("R4 R5 R7 grp-f7");
            end
        end

        // R2 R8: prefix runs of every length up to the full window.
        for (int n = 0; n <= 16; n++) begin
            for (int k = 0; k < 11; k++) begin
                fill();
                for (int i = 0; i < n; i++) wb[i] = plist[(i + k) % 11];
                if (n < 16) wb[n] = (k % 2 == 1) ? 8'hF7 : 8'h35;
                if (n < 15) wb[n+1] = 8'hC0 | 8'((k % 8) << 3);
                run_win("R2 R8 prefix-run");
            end
        end

        // R7: every first byte with a register-direct follower.
        for (int op = 0; op < 256; op++) begin
            fill();
            wb[0] = 8'(op);
            wb[1] = 8'hD8;
            run_win("R7 opcode-sweep");
        end

        // R1: strobe dropped, nothing reported next cycle.
        in_valid = 1'b0;
        @(negedge clk);
        report("R1 idle", !out_len_vld && !out_bad,
               out_len_vld, out_bad, out_len, out_pfx_cnt, out_lcp_stall, 0, 0, 0, 0, 0);

        // R1: a single strobe after idle gives one result then idle.
        fill(); wb[0] = 8'h66; wb[1] = 8'h35;
        run_win("R1 single");
        in_valid = 1'b0;
        @(negedge clk);
        report("R1 single-drop", !out_len_vld && !out_bad,
               out_len_vld, out_bad, out_len, out_pfx_cnt, out_lcp_stall, 0, 0, 0, 0, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule